// File: doc/BRIEF.md
# Run-Time Configurable Polar Block Encoder

This block turns a short message into a polar codeword whose length N (2, 4 or 8 by default) and message size K are picked for every request. The message bits go onto the K most reliable bit channels of the chosen length. Every other channel carries a fixed zero. The resulting vector u is multiplied over GF(2) by the generator matrix for that length, and the product is the codeword.

The generator matrix is not a stored constant. It is grown inside the block, one Kronecker step at a time, from the 2x2 kernel [[1,0],[1,1]]. The matrix for the requested length is then selected. Each codeword bit is a masked XOR over the rows of that matrix.

A request is a valid/ready transfer that carries the message, N and K together. The codeword comes back on a registered output with a one-cycle valid pulse. A request that is not legal produces a one-cycle error pulse and no codeword.

Top module: `polar_enc_top`

## Requirements
- R1: During reset and in the cycle after it is released, `out_valid` and `out_err` are low and `out_code` is zero. `in_ready` is low in reset and high from the first clock edge after release.
- R2: A legal request accepted at a clock edge (`in_valid` and `in_ready` both high) raises `out_valid` after that same edge for exactly one cycle, with `out_err` low. If no new request is accepted, `out_valid` is low again one cycle later.
- R3: Bit channels are ranked by reliability, least reliable first: by the number of ones in the channel index, with ties broken by the lower index. For N=8 this gives 0,1,2,4,3,5,6,7. The K channels at the reliable end carry the message, and message bit b goes to the b-th lowest of those channel indices.
- R4: Channels outside the K most reliable ones are zero, and bits of `in_msg` at positions K and above have no effect on `out_code`.
- R5: Bit j of `out_code` is the XOR of u[i] over every i whose index bits include all the bits of j, that is (i & j) == j. This is the Kronecker power of [[1,0],[1,1]].
- R6: Bits of `out_code` at positions N and above are zero.
- R7: For N=8, K=8 and an all-ones message, `out_code` is 8'b1000_0000.
- R8: A request is rejected if N is not a power of two between 2 and NMAX, if K is 0, or if K is larger than N. A rejected request raises `out_err` for one cycle after the accepting edge, keeps `out_valid` low and leaves `out_code` unchanged.
- R9: Requests may arrive on consecutive cycles with a different N and K on each. Each one is answered in the cycle after it was accepted.
- R10: In a cycle after which no request was accepted, `out_valid` and `out_err` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block accepts a request |
| in_msg | input | NMAX | Message bits, bit 0 first |
| in_n | input | LOGN+1 | Code length N as a binary value |
| in_k | input | LOGN+1 | Message size K as a binary value |
| out_valid | output | 1 | Codeword valid pulse |
| out_code | output | NMAX | Codeword, bit j is x[j] |
| out_err | output | 1 | Rejected request pulse |

## Verification
Two things can meet on the output in back-to-back traffic. An accepted legal request loads a new codeword, while a neighbouring rejected request must keep the previous codeword and raise only the error flag. The bench sends requests on consecutive cycles that alternate between legal ones of differing length and illegal ones. Across that stream it checks that every error pulse comes with the codeword of the last legal request, and that every valid pulse carries the codeword computed for its own request. A full sweep over every legal (N, K) pair and every 8-bit message is compared against a product computed in the bench from the subset rule and a fixed rank table.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

    // Number of ones in an index.
    function automatic int unsigned bit_ones(int unsigned v);
        int unsigned c;
        c = 0;
        for (int b = 0; b < 32; b++) begin
            if (v[b]) c++;
        end
        return c;
    endfunction

    // Position of channel idx in the reliability order of a length-n code:
    // fewer ones is less reliable, ties go to the lower index.
    function automatic int unsigned rel_rank(int unsigned idx, int unsigned n,
                                             int unsigned nmax);
        int unsigned r;
        r = 0;
        for (int unsigned j = 0; j < nmax; j++) begin
            if (j < n) begin
                if ((bit_ones(j) < bit_ones(idx)) ||
                    ((bit_ones(j) == bit_ones(idx)) && (j < idx)))
                    r++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/polar_gen_matrix.sv
module polar_gen_matrix #(
    parameter int NMAX = 8,
    parameter int LOGN = $clog2(NMAX),
    parameter int LVW  = $clog2(LOGN + 1)
) (
    input  logic [LVW-1:0]                 lvl,
    output logic [NMAX-1:0][NMAX-1:0]      g_sel
);
    // g_lv[l] holds the 2^l x 2^l generator in its top-left corner.
    logic [NMAX-1:0][NMAX-1:0] g_lv [LOGN+1];

    for (genvar lv = 0; lv <= LOGN; lv++) begin : g_level
        localparam int SZ = 1 << lv;
        localparam int H  = SZ / 2;
        for (genvar r = 0; r < NMAX; r++) begin : g_row
            for (genvar c = 0; c < NMAX; c++) begin : g_col
                if (lv == 0) begin : g_base
                    assign g_lv[lv][r][c] = (r == 0 && c == 0) ? 1'b1 : 1'b0;
                end else if (r >= SZ || c >= SZ) begin : g_out
                    assign g_lv[lv][r][c] = 1'b0;
                end else if (r < H) begin : g_top
                    if (c < H) begin : g_tl
                        assign g_lv[lv][r][c] = g_lv[lv-1][r][c];
                    end else begin : g_tr
                        assign g_lv[lv][r][c] = 1'b0;
                    end
                end else begin : g_bot
                    if (c < H) begin : g_bl
                        assign g_lv[lv][r][c] = g_lv[lv-1][r-H][c];
                    end else begin : g_br
                        assign g_lv[lv][r][c] = g_lv[lv-1][r-H][c-H];
                    end
                end
            end
        end
    end

    assign g_sel = g_lv[lvl];

endmodule

// File: rtl/polar_info_map.sv
module polar_info_map
    import polar_enc_pkg::*;
#(
    parameter int NMAX  = 8,
    parameter int LOGN  = $clog2(NMAX),
    parameter int LVW   = $clog2(LOGN + 1),
    parameter int CFG_W = LOGN + 1
) (
    input  logic [LVW-1:0]   lvl,
    input  logic [CFG_W-1:0] k,
    input  logic [NMAX-1:0]  msg,
    output logic [NMAX-1:0]  u
);
    int unsigned     n_i;
    int unsigned     k_i;
    logic [LOGN-1:0] cnt;

    always_comb begin
        n_i = 32'd1 << lvl;
        k_i = 32'(k);
        cnt = '0;
        u   = '0;
        for (int unsigned i = 0; i < NMAX; i++) begin
            if ((i < n_i) && (rel_rank(i, n_i, NMAX) + k_i >= n_i)) begin
                u[i] = msg[cnt];
                cnt  = cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/polar_xor_rows.sv
module polar_xor_rows #(
    parameter int NMAX = 8
) (
    input  logic [NMAX-1:0]            u,
    input  logic [NMAX-1:0][NMAX-1:0]  g,
    output logic [NMAX-1:0]            x
);
    always_comb begin
        x = '0;
        for (int i = 0; i < NMAX; i++) begin
            if (u[i]) x = x ^ g[i];
        end
    end

endmodule

// File: rtl/polar_enc_top.sv
module polar_enc_top #(
    parameter int NMAX = 8,
    parameter int LOGN = $clog2(NMAX),
    parameter int LVW  = $clog2(LOGN + 1),
    parameter int CFG_W = LOGN + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NMAX-1:0]  in_msg,
    input  logic [CFG_W-1:0] in_n,
    input  logic [CFG_W-1:0] in_k,
    output logic             out_valid,
    output logic [NMAX-1:0]  out_code,
    output logic             out_err
);
    typedef struct packed {
        logic            ready;
        logic            vld;
        logic            err;
        logic [NMAX-1:0] code;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic [LVW-1:0]            lvl;
    logic                      n_ok;
    logic                      k_ok;
    logic [NMAX-1:0]           u_vec;
    logic [NMAX-1:0][NMAX-1:0] g_mat;
    logic [NMAX-1:0]           x_vec;

    // Length decode: N must be 2^l with 1 <= l <= LOGN.
    always_comb begin
        lvl  = '0;
        n_ok = 1'b0;
        for (int l = 1; l <= LOGN; l++) begin
            if (32'(in_n) == (32'd1 << l)) begin
                lvl  = LVW'(l);
                n_ok = 1'b1;
            end
        end
        k_ok = (in_k != '0) && (in_k <= in_n);
    end

    polar_info_map #(.NMAX(NMAX), .LOGN(LOGN), .LVW(LVW), .CFG_W(CFG_W)) u_map (
        .lvl (lvl),
        .k   (in_k),
        .msg (in_msg),
        .u   (u_vec)
    );

    polar_gen_matrix #(.NMAX(NMAX), .LOGN(LOGN), .LVW(LVW)) u_gen (
        .lvl   (lvl),
        .g_sel (g_mat)
    );

    polar_xor_rows #(.NMAX(NMAX)) u_xor (
        .u (u_vec),
        .g (g_mat),
        .x (x_vec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.vld   = 1'b0;
        st_d.err   = 1'b0;
        if (in_valid && st_q.ready) begin
            if (n_ok && k_ok) begin
                st_d.vld  = 1'b1;
                st_d.code = x_vec;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = st_q.ready;
    assign out_valid = st_q.vld;
    assign out_err   = st_q.err;
    assign out_code  = st_q.code;

endmodule

// File: rtl/polar_enc_chk.sv
module polar_enc_chk #(
    parameter int NMAX  = 8,
    parameter int LOGN  = $clog2(NMAX),
    parameter int LVW   = $clog2(LOGN + 1),
    parameter int CFG_W = LOGN + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [NMAX-1:0]  in_msg,
    input logic [CFG_W-1:0] in_n,
    input logic [CFG_W-1:0] in_k,
    input logic             out_valid,
    input logic [NMAX-1:0]  out_code,
    input logic             out_err
);
    logic            req_ok;
    logic            fire;
    logic [NMAX-1:0] len_mask;

    always_comb begin
        req_ok = 1'b0;
        for (int l = 1; l <= LOGN; l++) begin
            if (32'(in_n) == (32'd1 << l)) req_ok = 1'b1;
        end
        if (in_k == '0 || in_k > in_n) req_ok = 1'b0;
        len_mask = '0;
        for (int b = 0; b < NMAX; b++) begin
            if (b < 32'(in_n)) len_mask[b] = 1'b1;
        end
    end

    assign fire = in_valid && in_ready;

    assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_ok |=> out_valid && !out_err);

    assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !req_ok |=> out_err && !out_valid);

    assert_reject_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !req_ok |=> $stable(out_code));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !out_valid && !out_err);

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_ok |=> (out_code & ~$past(len_mask)) == '0);

    assert_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (32'(in_n) == NMAX) && (32'(in_k) == NMAX) && (&in_msg)
        |=> out_code == {1'b1, {(NMAX-1){1'b0}}});

endmodule

bind polar_enc_top polar_enc_chk #(
    .NMAX(NMAX), .LOGN(LOGN), .LVW(LVW), .CFG_W(CFG_W)
) u_chk (.*);

// File: tb/polar_enc_top_test.sv
module polar_enc_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_msg = '0;
    logic [3:0] in_n = '0;
    logic [3:0] in_k = '0;
    logic       out_valid;
    logic [7:0] out_code;
    logic       out_err;

    int n_checks = 0;
    int n_fail = 0;

    // Expectation for the request driven in the previous cycle.
    logic       p_vld = 1'b0;
    logic       p_err = 1'b0;
    logic [7:0] p_code = '0;
    logic [7:0] last_code = '0;
    string      p_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    polar_enc_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_msg(in_msg), .in_n(in_n), .in_k(in_k),
        .out_valid(out_valid), .out_code(out_code), .out_err(out_err)
    );

    function automatic logic [7:0] ref_code(int n, int k, logic [7:0] msg);
        int rank8 [8] = '{0, 1, 2, 4, 3, 5, 6, 7};
        logic [7:0] u;
        logic [7:0] x;
        int m;
        u = '0;
        x = '0;
        m = 0;
        for (int i = 0; i < n; i++) begin
            int r;
            r = (n == 8) ? rank8[i] : i;
            if (r >= n - k) begin
                u[i] = msg[m];
                m++;
            end
        end
        for (int j = 0; j < 8; j++)
            for (int i = 0; i < 8; i++)
                if (((i & j) == j) && u[i]) x[j] = ~x[j];
        return x;
    endfunction

    function automatic bit is_legal(int n, int k);
        return (n == 2 || n == 4 || n == 8) && k >= 1 && k <= n;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check the previous cycle's expectation at the falling edge, then drive.
    task automatic step(bit v, int n, int k, logic [7:0] msg, string tag);
        @(negedge clk);
        check({p_tag, " valid"}, {7'd0, out_valid}, {7'd0, p_vld});
        check({p_tag, " error"}, {7'd0, out_err}, {7'd0, p_err});
        if (p_vld) begin
            check({p_tag, " code"}, out_code, p_code);
            last_code = p_code;
        end else if (p_err) begin
            check({p_tag, " code held"}, out_code, last_code);
        end
        in_valid = v;
        in_n = 4'(n);
        in_k = 4'(k);
        in_msg = msg;
        p_tag = v ? tag : "R10";
        p_vld = v && is_legal(n, k);
        p_err = v && !is_legal(n, k);
        p_code = p_vld ? ref_code(n, k, msg) : 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {7'd0, in_ready}, 8'h00);
        check("R1 valid in reset", {7'd0, out_valid}, 8'h00);
        check("R1 err in reset", {7'd0, out_err}, 8'h00);
        check("R1 code in reset", out_code, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {7'd0, in_ready}, 8'h01);
        check("R1 valid after reset", {7'd0, out_valid}, 8'h00);

        step(1'b0, 8, 8, 8'h00, "R10");
        step(1'b1, 8, 8, 8'hFF, "R7");
        step(1'b1, 8, 4, 8'h01, "R3");
        step(1'b1, 8, 5, 8'h02, "R3");
        step(1'b1, 8, 2, 8'hFC, "R4");
        step(1'b1, 2, 2, 8'hFF, "R6");
        step(1'b0, 2, 2, 8'h00, "R2");
        if (ref_code(8, 8, 8'hFF) != 8'h80 || ref_code(8, 5, 8'h02) != 8'h11) begin
            n_fail++;
            $display("FAIL R7 actual=bench expected=model");
        end

        for (int n = 2; n <= 8; n = n * 2)
            for (int k = 1; k <= n; k++)
                for (int m = 0; m < 256; m++)
                    step(1'b1, n, k, 8'(m), "R5");

        for (int n = 0; n < 16; n++)
            for (int k = 0; k < 16; k++)
                if (!is_legal(n, k)) begin
                    step(1'b1, 8, 3, 8'(n * 16 + k), "R9");
                    step(1'b1, n, k, 8'(k), "R8");
                end

        for (int r = 0; r < 8; r++) begin
            step(1'b1, 4, 1, 8'h01, "R9");
            step(1'b1, 8, 8, 8'(r * 37), "R9");
            step(1'b1, 3, 1, 8'h01, "R8");
            step(1'b1, 2, 1, 8'(r), "R9");
        end
        step(1'b0, 8, 8, 8'h00, "R10");
        step(1'b0, 8, 8, 8'h00, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule